// File: doc/BRIEF.md
# Completion Interrupt Moderator

This block sits between a DMA engine's completion events and the interrupt cause logic. For each traffic direction (receive and transmit) it holds back the completion interrupt. The interrupt is released only when one of two timers expires. The first is a burst timer. It starts at the first completion after the previous interrupt and limits how long completions may pile up. The second is an idle timer. It restarts on every completion and fires once the event stream has gone quiet for long enough. Either timer expiring produces a single one-cycle done pulse, and the direction then waits for its next completion.

Each timer has a control register and a threshold register. The control register holds clear, enable and tick-source bits. The tick source is either every core clock or an external microsecond strobe. Software reprograms a timer in three writes: first clear, then the threshold, then enable together with the tick choice. When both timers of a direction are disabled, completions pass straight through as done pulses. The receive direction also drives a threshold interrupt line. This line marks releases caused by the burst limit, and every release in pass-through mode.

Top module: `irq_moderator`

## Requirements
- R1: After reset every timer is disabled (pass-through mode) and the done and threshold outputs are low.
- R2: With both timers of a direction disabled, a completion sampled at a clock edge gives a done pulse in the cycle after that edge, and on receive a threshold pulse in the same cycle.
- R3: With the burst timer enabled on core-clock ticks and threshold T, a completion that opens a window at edge E gives done in the cycle after edge E+T, however many completions follow. A completion in that firing cycle opens the next window.
- R4: With the idle timer enabled on core-clock ticks and threshold T, done follows edge L+T, where L is the edge of the last completion. Each new completion restarts the idle count.
- R5: A release from either timer is a single one-cycle pulse, even when both timers expire on the same edge. It returns both timers to waiting, so the other timer does not fire later for the same window.
- R6: With the tick-select bit set, a timer advances only on edges where us_tick is high. A tick at the edge that opens a window does not count.
- R7: Write addresses are {direction (0 receive, 1 transmit), timer (0 burst, 1 idle), register (0 control, 1 threshold)}. Control bits are bit 0 clear, bit 1 enable and bit 2 tick select. A write with clear set disables that timer and zeroes its count, and the timer then never fires.
- R8: The receive threshold output pulses only with done, and only when the burst timer caused the release or the direction is in pass-through. The transmit threshold output is always low.
- R9: The two directions are independent: events and configuration of one never produce done on the other.
- R10: If both timers become disabled while a window is open, the pending completion is released as a done pulse one edge later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register select {direction, timer, control/threshold} |
| wr_data | input | CNT_W | Write value (control bits or threshold) |
| us_tick | input | 1 | External microsecond tick strobe |
| evt | input | 2 | Completion event pulses, bit 0 receive, bit 1 transmit |
| done_irq | output | 2 | Moderated done pulse per direction |
| thr_irq | output | 2 | Threshold pulse per direction (receive only) |

## Verification
The bench builds the block with an 8-bit counter width and the default threshold-line mask, so receive has the threshold line and transmit does not. With this counter width, thresholds of 3 to 20 ticks fit inside 32-cycle observation windows. The windows reach burst refire under continuous traffic, idle restarts, simultaneous expiry, sparse external ticks, a mid-window clear and the flush on disable. A scoreboard of expected per-cycle pulse masks, worked out from the requirements, covers both directions at once, so leakage between them is caught too.

// File: rtl/irqmod_pkg.sv
package irqmod_pkg;
    localparam int NDIR      = 2;
    localparam int DIR_W     = 1;
    localparam int ADDR_W    = DIR_W + 2;
    localparam int CTRL_CLR  = 0;
    localparam int CTRL_EN   = 1;
    localparam int CTRL_TSEL = 2;

    typedef enum logic {
        TMR_BURST = 1'b0,
        TMR_IDLE  = 1'b1
    } tmr_kind_e;
endpackage

// File: rtl/irqmod_timer.sv
module irqmod_timer
    import irqmod_pkg::*;
#(
    parameter int        CNT_W = 16,
    parameter tmr_kind_e KIND  = TMR_BURST
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_ctrl,
    input  logic             wr_thr,
    input  logic [CNT_W-1:0] wr_val,
    input  logic             us_tick,
    input  logic             evt,
    input  logic             armed,
    input  logic             rearm,
    output logic             en_o,
    output logic             hit_o
);
    typedef struct packed {
        logic             en;
        logic             tsel;
        logic [CNT_W-1:0] thr;
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t s_d, s_q;
    logic step;
    logic [CNT_W:0] wide;
    logic reached;

    always_comb begin
        s_d     = s_q;
        step    = s_q.en & (s_q.tsel ? us_tick : 1'b1);
        wide    = {1'b0, s_q.cnt} + (CNT_W+1)'(1);
        reached = (wide >= {1'b0, s_q.thr});
        hit_o   = step & armed & reached & ((KIND == TMR_IDLE) ? ~evt : 1'b1);

        // count progression
        if (rearm) begin
            s_d.cnt = '0;
        end else if (KIND == TMR_IDLE) begin
            if (evt)                s_d.cnt = '0;
            else if (armed && step) s_d.cnt = wide[CNT_W-1:0];
        end else begin
            if (!armed)             s_d.cnt = '0;
            else if (step)          s_d.cnt = wide[CNT_W-1:0];
        end

        // register writes
        if (wr_thr) s_d.thr = wr_val;
        if (wr_ctrl) begin
            if (wr_val[CTRL_CLR]) begin
                s_d.en   = 1'b0;
                s_d.tsel = 1'b0;
                s_d.cnt  = '0;
            end else begin
                s_d.en   = wr_val[CTRL_EN];
                s_d.tsel = wr_val[CTRL_TSEL];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign en_o = s_q.en;

    // R7: a clear write disables and zeroes the timer
    a_r7_clear_stops: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && wr_val[CTRL_CLR]) |=> (!s_q.en && s_q.cnt == '0));

    // R6: external tick mode holds the count on edges without a tick
    a_r6_hold_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.en && s_q.tsel && !us_tick && armed && !rearm && !wr_ctrl &&
         !((KIND == TMR_IDLE) && evt)) |=> $stable(s_q.cnt));

    generate
        if (KIND == TMR_IDLE) begin : g_idle_chk
            // R4: every completion restarts the idle count
            a_r4_idle_restart: assert property (@(posedge clk) disable iff (!rst_n)
                evt |=> (s_q.cnt == '0));
        end
    endgenerate
endmodule

// File: rtl/irqmod_dir.sv
module irqmod_dir
    import irqmod_pkg::*;
#(
    parameter int CNT_W   = 16,
    parameter bit HAS_THR = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [CNT_W-1:0] wr_val,
    input  logic             us_tick,
    input  logic             evt,
    output logic             done_o,
    output logic             thr_o
);
    typedef struct packed {
        logic armed;
        logic done;
        logic thr;
    } dir_t;

    dir_t d_d, d_q;
    logic b_en, b_hit, i_en, i_hit;
    logic pass, fire, thr_src;

    irqmod_timer #(.CNT_W(CNT_W), .KIND(TMR_BURST)) u_burst (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_ctrl (wr_en && wr_sel == 2'b00),
        .wr_thr  (wr_en && wr_sel == 2'b01),
        .wr_val  (wr_val),
        .us_tick (us_tick),
        .evt     (evt),
        .armed   (d_q.armed),
        .rearm   (fire),
        .en_o    (b_en),
        .hit_o   (b_hit)
    );

    irqmod_timer #(.CNT_W(CNT_W), .KIND(TMR_IDLE)) u_idle (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_ctrl (wr_en && wr_sel == 2'b10),
        .wr_thr  (wr_en && wr_sel == 2'b11),
        .wr_val  (wr_val),
        .us_tick (us_tick),
        .evt     (evt),
        .armed   (d_q.armed),
        .rearm   (fire),
        .en_o    (i_en),
        .hit_o   (i_hit)
    );

    assign pass = ~b_en & ~i_en;
    assign fire = pass ? (evt | d_q.armed) : (b_hit | i_hit);

    generate
        if (HAS_THR) begin : g_thr
            assign thr_src = pass ? fire : b_hit;
        end else begin : g_no_thr
            assign thr_src = 1'b0;
        end
    endgenerate

    always_comb begin
        d_d       = d_q;
        d_d.done  = fire;
        d_d.thr   = thr_src;
        d_d.armed = fire ? (evt & ~pass) : (d_q.armed | evt);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) d_q <= '0;
        else        d_q <= d_d;
    end

    assign done_o = d_q.done;
    assign thr_o  = d_q.thr;

    // R2: pass-through forwards each completion on the next edge
    a_r2_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
        (pass && evt) |=> d_q.done);

    // R8: threshold pulse never appears without done
    a_r8_thr_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        d_q.thr |-> d_q.done);

    // R5: a release with no new completion leaves the direction waiting
    a_r5_fire_disarm: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !evt) |=> !d_q.armed);
endmodule

// File: rtl/irq_moderator.sv
module irq_moderator
    import irqmod_pkg::*;
#(
    parameter int             CNT_W    = 16,
    parameter logic [NDIR-1:0] THR_MASK = 2'b01
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    input  logic              us_tick,
    input  logic [NDIR-1:0]   evt,
    output logic [NDIR-1:0]   done_irq,
    output logic [NDIR-1:0]   thr_irq
);
    generate
        for (genvar d = 0; d < NDIR; d++) begin : g_dir
            logic sel_wr;
            assign sel_wr = wr_en && (wr_addr[ADDR_W-1:2] == DIR_W'(d));

            irqmod_dir #(.CNT_W(CNT_W), .HAS_THR(THR_MASK[d])) u_dir (
                .clk     (clk),
                .rst_n   (rst_n),
                .wr_en   (sel_wr),
                .wr_sel  (wr_addr[1:0]),
                .wr_val  (wr_data),
                .us_tick (us_tick),
                .evt     (evt[d]),
                .done_o  (done_irq[d]),
                .thr_o   (thr_irq[d])
            );
        end
    endgenerate
endmodule

// File: tb/tb_irq_moderator.sv
module tb_irq_moderator;
    localparam int CLK_PERIOD = 10;
    localparam int CW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [2:0]    wr_addr = '0;
    logic [CW-1:0] wr_data = '0;
    logic          us_tick = 1'b0;
    logic [1:0]    evt = '0;
    logic [1:0]    done_irq, thr_irq;

    int n_chk = 0;
    int n_bad = 0;

    irq_moderator #(.CNT_W(CW)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .us_tick(us_tick), .evt(evt),
        .done_irq(done_irq), .thr_irq(thr_irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(logic act, logic exp, string req, string what);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic wr(logic [2:0] a, int v);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = CW'(v);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // clear, threshold, then enable/tick for both timers of a direction (R7 sequence)
    task automatic cfg(int d, bit be, bit bt, int bth, bit ie, bit it, int ith);
        wr({d[0], 2'b00}, 1);
        wr({d[0], 2'b01}, bth);
        wr({d[0], 2'b00}, (int'(be) << 1) | (int'(bt) << 2));
        wr({d[0], 2'b10}, 1);
        wr({d[0], 2'b11}, ith);
        wr({d[0], 2'b10}, (int'(ie) << 1) | (int'(it) << 2));
    endtask

    // bit j of ev/tk drives edge E+j; bit j of ed/et is expected after edge E+j
    task automatic win(int d, logic [31:0] ev, logic [31:0] tk, int wj,
                       logic [2:0] wa, int wv, logic [31:0] ed, logic [31:0] et,
                       string req);
        for (int j = 0; j < 32; j++) begin
            @(negedge clk);
            if (j > 0) begin
                chk(done_irq[d], ed[j-1], req, $sformatf("done dir%0d step %0d", d, j-1));
                chk(thr_irq[d], et[j-1], req, $sformatf("thr dir%0d step %0d", d, j-1));
                chk(done_irq[1-d], 1'b0, "R9", $sformatf("done other dir step %0d", j-1));
            end
            evt = '0;
            evt[d] = ev[j];
            us_tick = tk[j];
            wr_en = (j == wj);
            wr_addr = wa;
            wr_data = CW'(wv);
        end
        @(negedge clk);
        evt = '0; us_tick = 1'b0; wr_en = 1'b0;
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(done_irq[0], 1'b0, "R1", "rx done after reset");
        chk(done_irq[1], 1'b0, "R1", "tx done after reset");
        chk(thr_irq[0], 1'b0, "R1", "rx thr after reset");
        chk(thr_irq[1], 1'b0, "R1", "tx thr after reset");
    endtask

    task automatic t_pass();
        // R1/R2: no configuration, completions pass straight through
        win(0, 32'h13, 32'h0, -1, 3'b0, 0, 32'h13, 32'h13, "R2");
    endtask

    task automatic t_burst();
        cfg(0, 1, 0, 4, 0, 0, 0);
        // R3: continuous traffic, refire every 4 edges
        win(0, 32'h3FF, 32'h0, -1, 3'b0, 0, 32'h1110, 32'h1110, "R3");
    endtask

    task automatic t_idle_tx();
        cfg(0, 0, 0, 0, 0, 0, 0);
        cfg(1, 0, 0, 0, 1, 0, 5);
        // R4: last completion at edge 2, release after edge 7; R8 tx thr low
        win(1, 32'h5, 32'h0, -1, 3'b0, 0, 32'h80, 32'h0, "R4");
        cfg(1, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic t_both();
        cfg(0, 1, 0, 6, 1, 0, 3);
        // R5/R8: idle wins at 4, burst restarted; next window idle at 9
        win(0, 32'h43, 32'h0, -1, 3'b0, 0, 32'h210, 32'h0, "R5");
        cfg(0, 1, 0, 3, 1, 0, 3);
        // R5: both expire on edge 3, one pulse, thr from burst (R8)
        win(0, 32'h1, 32'h0, -1, 3'b0, 0, 32'h8, 32'h8, "R5");
    endtask

    task automatic t_ext_tick();
        cfg(0, 1, 1, 3, 0, 0, 0);
        // R6: ticks at 0 (ignored), 2, 5, 9 -> release after edge 9
        win(0, 32'h1, 32'h225, -1, 3'b0, 0, 32'h200, 32'h200, "R6");
    endtask

    task automatic t_clear();
        cfg(0, 1, 0, 4, 1, 0, 20);
        // R7: burst cleared at edge 2 never fires; idle releases at 20
        win(0, 32'h1, 32'h0, 2, 3'b000, 1, 32'h100000, 32'h0, "R7");
    endtask

    task automatic t_flush();
        cfg(0, 0, 0, 0, 1, 0, 20);
        // R10: idle cleared at edge 3 with open window -> release after edge 4
        win(0, 32'h1, 32'h0, 3, 3'b010, 1, 32'h10, 32'h10, "R10");
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_pass();
        t_burst();
        t_idle_tx();
        t_both();
        t_ext_tick();
        t_clear();
        t_flush();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule